// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle datapath made of seven general 8-bit registers, two operand buses, a destination decoder and an ALU. A 14-bit control word is applied each cycle. Two source selects steer a register or the external input onto operand bus A and operand bus B. A 5-bit operation code picks the ALU function, and a destination select names the register that captures the ALU result at the next rising clock edge.

The ALU result is driven onto `result_out` in every cycle, whichever destination is named. A pass-through operation with the destination set to "none" is therefore the way to read a register, or the input port, from outside. No instruction fetch, sequencing or status flags live here. A controller upstream supplies one control word per clock.

Top module: `ctrlword_datapath`

## Requirements
- R1: After a synchronous active-high reset, all seven registers hold zero.
- R2: Operand bus A carries `ext_in` when its select (control word bits 13:11) is 0, and register Rn when the select is n, for n from 1 to 7.
- R3: Operand bus B carries `ext_in` when its select (bits 10:8) is 0, and register Rn when the select is n.
- R4: With a destination select (bits 7:5) of n from 1 to 7, register Rn loads the ALU result at the rising edge and no other register changes. A destination select of 0 leaves every register unchanged.
- R5: `result_out` shows the combinational ALU result in every cycle, independent of the destination select. Operation code 00000 passes operand A through.
- R6: Arithmetic works modulo 256 with these codes (bits 4:0): 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R7: Bitwise operations use these codes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A.
- R8: Code 10000 shifts A right by one bit and code 11000 shifts A left by one bit. Both are logical shifts, and the vacated bit is filled with zero.
- R9: Any other operation code gives a result of zero. That zero is still written to the register named by the destination select.
- R10: When one register is both a source and the destination in the same cycle, the operand is the value from before the edge, and the new value is visible from the next cycle on.
- R11: The control word fields are packed as {source A, source B, destination, operation} from the most significant bit down. For example, 14'b010_011_001_00101 sets R1 to R2 - R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Control word {source A, source B, destination, operation} |
| ext_in | input | 8 | External input, selectable on either operand bus with code 0 |
| result_out | output | 8 | ALU result, driven every cycle |

## Verification
The assertions assume that `ctrl_word`, `ext_in` and `rst` hold known, steady values around each rising edge. They also assume that the result captured by a destination register equals the value `result_out` showed just before that edge. The bench meets these assumptions by changing every input only at the falling edge of the clock and by reading `result_out` shortly after, so each control word is stable for the full half-cycle before its write edge. The operand, no-write and unused-code properties all depend on clean select fields, so every stimulus word is built from in-range 3-bit and 5-bit values.

// File: rtl/cwdp_pkg.sv
`timescale 1ns/1ps
package cwdp_pkg;

  // ALU operation codes (sparse 5-bit set)
  typedef enum logic [4:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SRL  = 5'b10000,
    OP_SLL  = 5'b11000
  } alu_op_e;

  localparam int OP_W = $bits(alu_op_e);

  // True for the codes that have a defined ALU function
  function automatic logic op_is_known(input logic [OP_W-1:0] code);
    case (alu_op_e'(code))
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC,
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SRL, OP_SLL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cwdp_src_mux.sv
`timescale 1ns/1ps
// Operand bus multiplexer: code 0 picks the external input, code n picks Rn
module cwdp_src_mux #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 7,
  parameter int SEL_W    = 3
) (
  input  logic [SEL_W-1:0]           sel,
  input  logic [DATA_W-1:0]          ext,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          bus
);

  always_comb begin
    bus = ext;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel == SEL_W'(i + 1)) bus = regs_flat[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/cwdp_dest_dec.sv
`timescale 1ns/1ps
// Destination decoder: code 0 enables nothing, code n enables register n
module cwdp_dest_dec #(
  parameter int NUM_REGS = 7,
  parameter int SEL_W    = 3
) (
  input  logic [SEL_W-1:0]    sel_d,
  output logic [NUM_REGS-1:0] load_vec
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign load_vec[i] = (sel_d == SEL_W'(i + 1));
  end

endmodule

// File: rtl/cwdp_regbank.sv
`timescale 1ns/1ps
// General registers, each with its own load enable
module cwdp_regbank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS-1:0]        load_vec,
  input  logic [DATA_W-1:0]          din,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)              q <= '0;
      else if (load_vec[i]) q <= din;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/cwdp_alu.sv
`timescale 1ns/1ps
module cwdp_alu
  import cwdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] y
);

  function automatic logic [DATA_W-1:0] alu_calc(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] z,
    input logic [OP_W-1:0]   code
  );
    logic [DATA_W-1:0] r;
    case (alu_op_e'(code))
      OP_PASS: r = x;
      OP_INC:  r = x + DATA_W'(1);
      OP_ADD:  r = x + z;
      OP_SUB:  r = x - z;
      OP_DEC:  r = x - DATA_W'(1);
      OP_AND:  r = x & z;
      OP_OR:   r = x | z;
      OP_XOR:  r = x ^ z;
      OP_NOT:  r = ~x;
      OP_SRL:  r = {1'b0, x[DATA_W-1:1]};
      OP_SLL:  r = {x[DATA_W-2:0], 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

  assign y = alu_calc(a, b, op);

endmodule

// File: rtl/ctrlword_datapath.sv
`timescale 1ns/1ps
module ctrlword_datapath
  import cwdp_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int NUM_REGS = 7,
  localparam int SEL_W    = $clog2(NUM_REGS + 1),
  localparam int CW_W     = 3 * SEL_W + OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] result_out
);

  localparam int SD_LO = OP_W;
  localparam int SB_LO = OP_W + SEL_W;
  localparam int SA_LO = OP_W + 2 * SEL_W;

  // Decoded control fields
  logic [SEL_W-1:0] sel_d;
  logic [OP_W-1:0]  opr;
  logic [SEL_W-1:0] src_sel [2];
  logic [DATA_W-1:0] src_bus [2];

  assign src_sel[0] = ctrl_word[SA_LO +: SEL_W];
  assign src_sel[1] = ctrl_word[SB_LO +: SEL_W];
  assign sel_d      = ctrl_word[SD_LO +: SEL_W];
  assign opr        = ctrl_word[OP_W-1:0];

  // Named internal events, observed by the bound checker
  logic [NUM_REGS*DATA_W-1:0] reg_flat;
  logic [NUM_REGS-1:0]        load_vec;
  logic [DATA_W-1:0]          bus_a;
  logic [DATA_W-1:0]          bus_b;
  logic [DATA_W-1:0]          alu_y;

  for (genvar k = 0; k < 2; k++) begin : g_bus
    cwdp_src_mux #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
    ) u_mux (
      .sel(src_sel[k]), .ext(ext_in), .regs_flat(reg_flat), .bus(src_bus[k])
    );
  end

  assign bus_a = src_bus[0];
  assign bus_b = src_bus[1];

  cwdp_alu #(.DATA_W(DATA_W)) u_alu (
    .a(bus_a), .b(bus_b), .op(opr), .y(alu_y)
  );

  cwdp_dest_dec #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec (
    .sel_d(sel_d), .load_vec(load_vec)
  );

  cwdp_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst), .load_vec(load_vec), .din(alu_y), .regs_flat(reg_flat)
  );

  assign result_out = alu_y;

endmodule

// File: rtl/cwdp_checker.sv
`timescale 1ns/1ps
module cwdp_checker
  import cwdp_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int NUM_REGS = 7,
  localparam int SEL_W    = $clog2(NUM_REGS + 1),
  localparam int CW_W     = 3 * SEL_W + OP_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic [CW_W-1:0]            ctrl_word,
  input logic [DATA_W-1:0]          ext_in,
  input logic [DATA_W-1:0]          result_out,
  input logic [DATA_W-1:0]          bus_a,
  input logic [DATA_W-1:0]          bus_b,
  input logic [NUM_REGS-1:0]        load_vec,
  input logic [NUM_REGS*DATA_W-1:0] reg_flat
);

  localparam int SD_LO = OP_W;
  localparam int SB_LO = OP_W + SEL_W;
  localparam int SA_LO = OP_W + 2 * SEL_W;

  logic [SEL_W-1:0] c_sa, c_sb, c_sd;
  logic [OP_W-1:0]  c_op;
  assign c_sa = ctrl_word[SA_LO +: SEL_W];
  assign c_sb = ctrl_word[SB_LO +: SEL_W];
  assign c_sd = ctrl_word[SD_LO +: SEL_W];
  assign c_op = ctrl_word[OP_W-1:0];

  assert_onehot_load_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_vec));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (c_sd == '0) |=> $stable(reg_flat));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    // R10: the register takes the result shown before the edge
    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
      (c_sd == SEL_W'(i + 1)) |=> (reg_flat[i*DATA_W +: DATA_W] == $past(result_out)));
  end

  assert_ext_a_R2: assert property (@(posedge clk) disable iff (rst)
    (c_sa == '0) |-> (bus_a == ext_in));

  assert_ext_b_R3: assert property (@(posedge clk) disable iff (rst)
    (c_sb == '0) |-> (bus_b == ext_in));

  assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_W'(OP_PASS)) |-> (result_out == bus_a));

  assert_srl_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_W'(OP_SRL)) |-> (result_out[DATA_W-1] == 1'b0));

  assert_sll_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_W'(OP_SLL)) |-> (result_out[0] == 1'b0));

  assert_unused_R9: assert property (@(posedge clk) disable iff (rst)
    !op_is_known(c_op) |-> (result_out == '0));

endmodule

bind ctrlword_datapath cwdp_checker #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_cwdp_checker (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .result_out(result_out), .bus_a(bus_a), .bus_b(bus_b),
  .load_vec(load_vec), .reg_flat(reg_flat)
);

// File: tb/test_ctrlword_datapath.sv
`timescale 1ns/1ps
module test_ctrlword_datapath;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  result_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [7:0] mreg [1:7];
  int unsigned seed = 32'h1357_9bdf;

  always #4 clk = ~clk;  // 125 MHz

  ctrlword_datapath i_ctrlword_datapath (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in), .result_out(result_out)
  );

  // Expected ALU result, computed with plain integer arithmetic
  function automatic logic [7:0] expect_alu(int code, int a, int b);
    int r;
    case (code)
      0:  r = a;
      1:  r = a + 1;
      2:  r = a + b;
      5:  r = a + 256 - b;
      6:  r = a + 255;
      8:  r = a & b;
      10: r = a | b;
      12: r = a ^ b;
      14: r = 255 - a;
      16: r = a / 2;
      24: r = a * 2;
      default: r = 0;
    endcase
    return 8'(r % 256);
  endfunction

  function automatic string req_of(int code);
    case (code)
      0:             return "R5";
      1, 2, 5, 6:    return "R6";
      8, 10, 12, 14: return "R7";
      16, 24:        return "R8";
      default:       return "R9";
    endcase
  endfunction

  function automatic int src_val(int sel);
    return (sel == 0) ? int'(ext_in) : int'(mreg[sel]);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Apply one control word at the falling edge, check the output, track the write
  task automatic step(int sa, int sb, int sd, int op, logic [7:0] ext, string req);
    logic [7:0] exp;
    @(negedge clk);
    ctrl_word = {3'(sa), 3'(sb), 3'(sd), 5'(op)};
    ext_in = ext;
    #1;
    exp = expect_alu(op, src_val(sa), src_val(sb));
    check(req, result_out, exp);
    @(posedge clk);
    if (sd != 0) mreg[sd] = exp;
  endtask

  // Read a register through operand A with pass-through and no destination
  task automatic peek(int r, string req);
    step(r, 0, 0, 0, 8'hA5, req);
  endtask

  initial begin
    for (int r = 1; r <= 7; r++) mreg[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    for (int r = 1; r <= 7; r++) peek(r, "R1");
    // R2: external input on bus A
    step(0, 0, 0, 0, 8'h3C, "R2");
    // R4: load each register from the input port, then read back
    for (int r = 1; r <= 7; r++) step(0, 0, r, 0, 8'(r * 37 + 11), "R4");
    for (int r = 1; r <= 7; r++) peek(r, "R4");
    // R3: each register on bus B, added to a zero input on bus A
    for (int r = 1; r <= 7; r++) step(0, r, 0, 2, 8'h00, "R3");
    step(0, 0, 0, 2, 8'h21, "R3");

    // Sweep of every source pair and every operation code, no writes
    for (int sa = 0; sa < 8; sa++)
      for (int sb = 0; sb < 8; sb++)
        for (int op = 0; op < 32; op++)
          step(sa, sb, 0, op, 8'(sa * 29 + sb * 7 + op * 3 + 128), req_of(op));
    // R4: no-destination words left every register untouched
    for (int r = 1; r <= 7; r++) peek(r, "R4");

    // Mixed words with writes, including self-referencing ones (R10)
    for (int n = 0; n < 600; n++) begin
      int sa, sb, sd, op;
      seed = seed * 32'd1103515245 + 32'd12345;
      sa = int'(seed[30:28]);
      sb = int'(seed[27:25]);
      sd = int'(seed[24:22]);
      op = int'(seed[21:17]);
      step(sa, sb, sd, op, seed[15:8], req_of(op));
    end
    for (int r = 1; r <= 7; r++) peek(r, "R4");

    // R10: same register as source and destination
    step(0, 0, 5, 0, 8'h7E, "R10");
    step(5, 0, 5, 1, 8'h00, "R10");   // 7E -> 7F, operand is old value
    step(5, 5, 5, 2, 8'h00, "R10");   // 7F + 7F = FE
    peek(5, "R10");

    // R9: unused code writes zero to its destination
    step(0, 0, 3, 0, 8'hC3, "R9");
    step(3, 3, 3, 3, 8'h00, "R9");
    peek(3, "R9");

    // R11: literal control word, R1 <= R2 - R3
    step(0, 0, 2, 0, 8'h50, "R11");
    step(0, 0, 3, 0, 8'h13, "R11");
    @(negedge clk);
    ctrl_word = 14'b010_011_001_00101;
    #1;
    check("R11", result_out, 8'h3D);
    @(posedge clk);
    mreg[1] = 8'h3D;
    peek(1, "R11");

    // R1: reset in mid-run clears everything
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int r = 1; r <= 7; r++) mreg[r] = '0;
    for (int r = 1; r <= 7; r++) peek(r, "R1");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule